// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Master

This block turns single requests from a host into complete serial frames for a small three-wire serial EEPROM with a chip-select line. A request can be a 16-bit word read, an 8-bit byte read, a 16-bit word write, or a command that arms or disarms programming. The block drives chip select, the serial clock and the data line toward the memory, and samples the data line coming back.

Each command is wrapped by one dummy clock pulse on entry and one on exit. Command bits go out most-significant bit first. After a word write the block stops driving data, keeps the device selected, and polls the returned data line until it shows the ready level, up to a fixed number of checks. The serial clock phase length, the delay after selection and the poll interval are all given in system-clock cycles. The host sees one `rsp_done` pulse per request, together with the read result and a timeout flag.

Top module: `uwire_eeprom_master`

## Requirements
- R1: When a request is accepted, `ee_cs` rises with `ee_sclk` and `ee_di` low. Exactly one full clock pulse (low phase, then high phase) follows before the first command bit.
- R2: Command bits are sent MSB first with one full pulse each. `ee_di` changes only at the start of a low phase. `ee_di` returns to 0 after the last bit. The opcodes are 3 bits and include the start bit: read is 110 and write is 101.
- R3: A word read (`req_op`=0) sends 110 followed by `req_addr[ADDR_W-1:0]`, then clocks in 16 bits. Each bit of `ee_do` is sampled at the end of a high phase, and the first bit sampled becomes bit 15 of `rsp_rdata`. During those bits `ee_di` and `ee_di_en` are 0.
- R4: A byte read (`req_op`=1) sends 110 followed by `req_addr[ADDR_W:0]`, one address bit more than a word read, then clocks in 8 bits. The byte is returned in `rsp_rdata[7:0]` with the upper byte 0. Requests that are not reads return 0.
- R5: Write-enable (`req_op`=3) sends 10011 and write-disable (`req_op`=4) sends 10000. Each is followed by ADDR_W-2 zeros, so the frame has 3+ADDR_W bits.
- R6: A word write (`req_op`=2) sends 101, then `req_addr[ADDR_W-1:0]`, then `req_wdata` MSB first. After that it drops `ee_di_en` and keeps `ee_cs` high while it polls.
- R7: The first poll sample is taken SETTLE_CYC cycles after the last write pulse ends, and further samples follow every POLL_CYC cycles. A sample of 1 starts the exit pulse.
- R8: If POLL_MAX samples all read 0, the operation ends anyway and `rsp_timeout` is 1 together with `rsp_done`. Otherwise `rsp_timeout` is 0.
- R9: Every command ends with `ee_cs` and `ee_di` low, followed by one full clock pulse. `rsp_done` is high for exactly one cycle after that pulse.
- R10: Every `ee_sclk` phase lasts at least PHASE_CYC cycles. `req_ready` is 1 only while idle, so no request is taken mid-command.
- R11: `rsp_done` rises 2·PHASE_CYC·N cycles after acceptance, where N counts all pulses of the command. For a write, it rises instead 2·PHASE_CYC·(ADDR_W+20) + SETTLE_CYC + (k−1)·POLL_CYC + 2·PHASE_CYC cycles after acceptance, where k is the number of the sample that ended polling.
- R12: After reset, `ee_cs`, `ee_sclk`, `ee_di` and `rsp_done` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken this cycle if valid |
| req_op | input | 3 | 0 word read, 1 byte read, 2 word write, 3 write enable, 4 write disable |
| req_addr | input | ADDR_W+1 | Address; the top bit is used only by byte reads |
| req_wdata | input | 16 | Word to program |
| rsp_done | output | 1 | One-cycle end-of-command strobe |
| rsp_rdata | output | 16 | Read result, valid with `rsp_done` |
| rsp_timeout | output | 1 | Polling ran out, valid with `rsp_done` |
| ee_cs | output | 1 | Chip select to memory |
| ee_sclk | output | 1 | Serial clock to memory |
| ee_di | output | 1 | Serial data to memory |
| ee_di_en | output | 1 | High while the block owns the data line |
| ee_do | input | 1 | Serial data from memory |

## Verification
Every result arrives at a cycle count after acceptance that is fixed by the requirements. For reads and the enable commands this is 2·PHASE_CYC times the pulse count. For writes it also depends on which poll sample first saw the ready level. The bench counts rising clock edges from the accepting edge and samples 1 ns after each edge. It requires `rsp_done` at exactly the predicted count and low on the next cycle. The bench's memory model presents each read bit on the falling clock edge that precedes its sampling phase, and it raises the ready level between two known poll instants. A sampling point shifted by even one phase therefore changes the observed data or cycle count.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

   localparam int OPC_W  = 3;
   localparam int DATA_W = 16;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      OP_RD_WORD = 3'd0,
      OP_RD_BYTE = 3'd1,
      OP_WR_WORD = 3'd2,
      OP_WR_EN   = 3'd3,
      OP_WR_DIS  = 3'd4
   } uw_op_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_PULSE,
      ST_POLL
   } uw_state_e;

   typedef enum logic [1:0] {
      SG_ENTRY,
      SG_CMD,
      SG_RECV,
      SG_EXIT
   } uw_stage_e;

endpackage

// File: rtl/uwire_phase_timer.sv
module uwire_phase_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

   // A non-zero reload must hold the phase open on the following cycle.
   assert_timer_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val != '0) |=> !zero);

endmodule

// File: rtl/uwire_frame_shift.sv
module uwire_frame_shift import uwire_pkg::*; #(
   parameter int ADDR_W = 6,
   parameter int SH_W   = OPC_W + ADDR_W + 1 + DATA_W,
   parameter int LEN_W  = $clog2(SH_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  uw_op_e           op,
   input  logic [ADDR_W:0]  addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic             shift,
   output logic             msb,
   output logic [LEN_W-1:0] nbits
);

   localparam int CTL_PAD = SH_W - 5;

   logic [SH_W-1:0]  sh_q;
   logic [LEN_W-1:0] len_q;
   logic [SH_W-1:0]  frame;
   logic [LEN_W-1:0] frame_len;

   // Left-aligned frames: the next bit to send is always the top bit.
   always_comb begin
      unique case (op)
         OP_RD_BYTE: begin
            frame     = {3'b110, addr[ADDR_W:0], {DATA_W{1'b0}}};
            frame_len = LEN_W'(OPC_W + ADDR_W + 1);
         end
         OP_WR_WORD: begin
            frame     = {3'b101, addr[ADDR_W-1:0], wdata, 1'b0};
            frame_len = LEN_W'(OPC_W + ADDR_W + DATA_W);
         end
         OP_WR_EN: begin
            frame     = {5'b10011, {CTL_PAD{1'b0}}};
            frame_len = LEN_W'(OPC_W + ADDR_W);
         end
         OP_WR_DIS: begin
            frame     = {5'b10000, {CTL_PAD{1'b0}}};
            frame_len = LEN_W'(OPC_W + ADDR_W);
         end
         default: begin
            frame     = {3'b110, addr[ADDR_W-1:0], {(DATA_W+1){1'b0}}};
            frame_len = LEN_W'(OPC_W + ADDR_W);
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         len_q <= '0;
      end else if (load) begin
         sh_q  <= frame;
         len_q <= frame_len;
      end else if (shift) begin
         sh_q  <= {sh_q[SH_W-2:0], 1'b0};
      end
   end

   assign msb   = sh_q[SH_W-1];
   assign nbits = len_q;

   // Every loaded frame opens with the start bit.
   assert_start_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> msb);

endmodule

// File: rtl/uwire_rx_shift.sv
module uwire_rx_shift #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         sample,
   input  logic         bit_in,
   output logic [W-1:0] q
);

   logic [W-1:0] q_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_r <= '0;
      else if (clear)  q_r <= '0;
      else if (sample) q_r <= {q_r[W-2:0], bit_in};
   end

   assign q = q_r;

   // A fresh command starts from an empty result, so short reads zero-extend.
   assert_rx_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (q == '0));

endmodule

// File: rtl/uwire_eeprom_master.sv
module uwire_eeprom_master import uwire_pkg::*; #(
   parameter int ADDR_W     = 6,
   parameter int PHASE_CYC  = 45,
   parameter int SETTLE_CYC = 25,
   parameter int POLL_CYC   = 100,
   parameter int POLL_MAX   = 100
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [2:0]          req_op,
   input  logic [ADDR_W:0]     req_addr,
   input  logic [DATA_W-1:0]   req_wdata,
   output logic                rsp_done,
   output logic [DATA_W-1:0]   rsp_rdata,
   output logic                rsp_timeout,
   output logic                ee_cs,
   output logic                ee_sclk,
   output logic                ee_di,
   output logic                ee_di_en,
   input  logic                ee_do
);

   localparam int SH_W  = OPC_W + ADDR_W + 1 + DATA_W;
   localparam int LEN_W = $clog2(SH_W + 1);
   localparam int MAXC  = (PHASE_CYC > SETTLE_CYC)
                        ? ((PHASE_CYC > POLL_CYC) ? PHASE_CYC : POLL_CYC)
                        : ((SETTLE_CYC > POLL_CYC) ? SETTLE_CYC : POLL_CYC);
   localparam int CNT_W = (MAXC > 2) ? $clog2(MAXC) : 1;
   localparam int PW    = $clog2(POLL_MAX + 1);
   localparam int RUN_W = $clog2(PHASE_CYC + 1);
   localparam logic [CNT_W-1:0] PH_LD = CNT_W'(PHASE_CYC - 1);
   localparam logic [CNT_W-1:0] ST_LD = CNT_W'(SETTLE_CYC - 1);
   localparam logic [CNT_W-1:0] PO_LD = CNT_W'(POLL_CYC - 1);

   // Elaboration-time parameter checks.
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must be at least 2 to hold the extended opcodes");
   end
   if (PHASE_CYC < 1 || SETTLE_CYC < 1 || POLL_CYC < 1) begin : g_bad_timing
      $error("timing parameters must be at least one cycle");
   end
   if (POLL_MAX < 1) begin : g_bad_poll
      $error("POLL_MAX must be at least 1");
   end

   uw_state_e        state_q, state_n;
   uw_stage_e        stage_q, stage_n;
   uw_op_e           op_q, op_n;
   logic             cs_q, cs_n, sclk_q, sclk_n, di_q, di_n, den_q, den_n;
   logic             to_q, to_n, done_q, done_n;
   logic [LEN_W-1:0] left_q, left_n;
   logic [PW-1:0]    polls_q, polls_n;

   logic             tmr_load, tmr_zero;
   logic [CNT_W-1:0] tmr_val;
   logic             sh_load, sh_shift, sh_msb;
   logic [LEN_W-1:0] sh_nbits;
   logic             rx_clear, rx_sample;

   uwire_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
   );

   uwire_frame_shift #(.ADDR_W(ADDR_W), .SH_W(SH_W), .LEN_W(LEN_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .load(sh_load), .op(uw_op_e'(req_op)),
      .addr(req_addr), .wdata(req_wdata), .shift(sh_shift),
      .msb(sh_msb), .nbits(sh_nbits)
   );

   uwire_rx_shift #(.W(DATA_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .clear(rx_clear), .sample(rx_sample),
      .bit_in(ee_do), .q(rsp_rdata)
   );

   always_comb begin
      state_n   = state_q;
      stage_n   = stage_q;
      op_n      = op_q;
      cs_n      = cs_q;
      sclk_n    = sclk_q;
      di_n      = di_q;
      den_n     = den_q;
      to_n      = to_q;
      left_n    = left_q;
      polls_n   = polls_q;
      done_n    = 1'b0;
      tmr_load  = 1'b0;
      tmr_val   = PH_LD;
      sh_load   = 1'b0;
      sh_shift  = 1'b0;
      rx_clear  = 1'b0;
      rx_sample = 1'b0;

      unique case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               state_n  = ST_PULSE;
               stage_n  = SG_ENTRY;
               op_n     = uw_op_e'(req_op);
               cs_n     = 1'b1;
               sclk_n   = 1'b0;
               di_n     = 1'b0;
               den_n    = 1'b1;
               to_n     = 1'b0;
               tmr_load = 1'b1;
               sh_load  = 1'b1;
               rx_clear = 1'b1;
            end
         end

         ST_PULSE: begin
            if (tmr_zero) begin
               tmr_load = 1'b1;
               if (!sclk_q) begin
                  sclk_n = 1'b1;
               end else begin
                  sclk_n = 1'b0;
                  unique case (stage_q)
                     SG_ENTRY: begin
                        stage_n  = SG_CMD;
                        di_n     = sh_msb;
                        sh_shift = 1'b1;
                        left_n   = sh_nbits - 1'b1;
                     end
                     SG_CMD: begin
                        if (left_q != '0) begin
                           di_n     = sh_msb;
                           sh_shift = 1'b1;
                           left_n   = left_q - 1'b1;
                        end else begin
                           di_n  = 1'b0;
                           den_n = 1'b0;
                           unique case (op_q)
                              OP_WR_WORD: begin
                                 state_n = ST_POLL;
                                 tmr_val = ST_LD;
                                 polls_n = '0;
                              end
                              OP_WR_EN, OP_WR_DIS: begin
                                 stage_n = SG_EXIT;
                                 cs_n    = 1'b0;
                              end
                              OP_RD_BYTE: begin
                                 stage_n = SG_RECV;
                                 left_n  = LEN_W'(BYTE_W);
                              end
                              default: begin
                                 stage_n = SG_RECV;
                                 left_n  = LEN_W'(DATA_W);
                              end
                           endcase
                        end
                     end
                     SG_RECV: begin
                        rx_sample = 1'b1;
                        left_n    = left_q - 1'b1;
                        if (left_q == LEN_W'(1)) begin
                           stage_n = SG_EXIT;
                           cs_n    = 1'b0;
                        end
                     end
                     default: begin
                        state_n = ST_IDLE;
                        done_n  = 1'b1;
                     end
                  endcase
               end
            end
         end

         default: begin
            if (tmr_zero) begin
               tmr_load = 1'b1;
               if (ee_do || polls_q == PW'(POLL_MAX - 1)) begin
                  to_n    = !ee_do;
                  state_n = ST_PULSE;
                  stage_n = SG_EXIT;
                  cs_n    = 1'b0;
               end else begin
                  polls_n = polls_q + 1'b1;
                  tmr_val = PO_LD;
               end
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         stage_q <= SG_ENTRY;
         op_q    <= OP_RD_WORD;
         cs_q    <= 1'b0;
         sclk_q  <= 1'b0;
         di_q    <= 1'b0;
         den_q   <= 1'b0;
         to_q    <= 1'b0;
         done_q  <= 1'b0;
         left_q  <= '0;
         polls_q <= '0;
      end else begin
         state_q <= state_n;
         stage_q <= stage_n;
         op_q    <= op_n;
         cs_q    <= cs_n;
         sclk_q  <= sclk_n;
         di_q    <= di_n;
         den_q   <= den_n;
         to_q    <= to_n;
         done_q  <= done_n;
         left_q  <= left_n;
         polls_q <= polls_n;
      end
   end

   assign req_ready   = (state_q == ST_IDLE);
   assign rsp_done    = done_q;
   assign rsp_timeout = to_q;
   assign ee_cs       = cs_q;
   assign ee_sclk     = sclk_q;
   assign ee_di       = di_q;
   assign ee_di_en    = den_q;

   // Cycles the serial clock has held its level, saturating at PHASE_CYC.
   logic [RUN_W-1:0] run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      run_q <= '0;
      else if (sclk_n != sclk_q)       run_q <= RUN_W'(1);
      else if (run_q != RUN_W'(PHASE_CYC)) run_q <= run_q + 1'b1;
   end

   assert_phase_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_n != sclk_q) |-> (run_q == RUN_W'(PHASE_CYC)));

   assert_accept_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (ee_cs && !ee_sclk && !ee_di));

   assert_recv_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PULSE && stage_q == SG_RECV) |-> (!ee_di && !ee_di_en));

   assert_done_cs_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> (!ee_cs && !ee_sclk && $past(ee_sclk)));

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   assert_timeout_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_timeout |-> (rsp_done || !req_ready || $past(rsp_done) || $stable(rsp_timeout)));

   assert_poll_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_POLL) |-> (ee_cs && !ee_sclk && !ee_di_en));

endmodule

// File: tb/sim_uwire_eeprom_master.sv
`timescale 1ns/1ps
module sim_uwire_eeprom_master;

   localparam int AW = 6;
   localparam int BP = 2;
   localparam int BS = 3;
   localparam int BQ = 5;
   localparam int BM = 100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [2:0]  req_op = 3'd0;
   logic [AW:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        rsp_done;
   logic [15:0] rsp_rdata;
   logic        rsp_timeout;
   logic        ee_cs, ee_sclk, ee_di, ee_di_en, ee_do;

   int errors = 0;
   int checks = 0;

   always #5 clk = ~clk;

   uwire_eeprom_master #(.ADDR_W(AW), .PHASE_CYC(BP), .SETTLE_CYC(BS),
                         .POLL_CYC(BQ), .POLL_MAX(BM)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout),
      .ee_cs(ee_cs), .ee_sclk(ee_sclk), .ee_di(ee_di), .ee_di_en(ee_di_en),
      .ee_do(ee_do)
   );

   // Memory model
   int          m_cmd_bits = 0;
   int          m_data_bits = 0;
   logic [15:0] m_word = '0;
   logic [31:0] m_cap = '0;
   int          m_cnt = 0;
   int          m_edges = 0;
   logic        m_entry_bad = 1'b0;
   logic        m_quiet_bad = 1'b0;
   logic        m_exit_seen = 1'b0;
   logic        m_do = 1'b0;
   logic        wr_mode = 1'b0;
   logic        wr_do = 1'b0;
   assign ee_do = wr_mode ? wr_do : m_do;

   always @(posedge ee_sclk) begin
      m_edges = m_edges + 1;
      if (ee_cs) begin
         m_cnt = m_cnt + 1;
         if (m_cnt == 1 && (ee_di || !ee_di_en)) m_entry_bad = 1'b1;
         if (m_cnt >= 2 && m_cnt <= 1 + m_cmd_bits) m_cap = {m_cap[30:0], ee_di};
         if (m_cnt > 1 + m_cmd_bits && (ee_di || ee_di_en)) m_quiet_bad = 1'b1;
      end else begin
         if (!ee_di) m_exit_seen = 1'b1;
      end
   end

   always @(negedge ee_sclk) begin
      if (ee_cs && !wr_mode && m_cnt >= 1 + m_cmd_bits) begin
         if (m_cnt - 1 - m_cmd_bits < m_data_bits)
            m_do = m_word[m_data_bits - 1 - (m_cnt - 1 - m_cmd_bits)];
      end
   end

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   int          got_cyc;
   logic [15:0] got_rdata;
   logic        got_to;
   logic        got_acc_ok;
   logic        got_busy_ready;
   logic        got_done_after;

   task automatic run_req(input logic [2:0] op, input logic [AW:0] addr,
                          input logic [15:0] wd, input int cmd_bits,
                          input int data_bits, input logic [15:0] word,
                          input int ready_at);
      m_cmd_bits = cmd_bits; m_data_bits = data_bits; m_word = word;
      m_cap = '0; m_cnt = 0; m_edges = 0; m_do = 1'b0;
      m_entry_bad = 1'b0; m_quiet_bad = 1'b0; m_exit_seen = 1'b0;
      wr_mode = (op == 3'd2); wr_do = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd;
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      got_acc_ok = ee_cs && !ee_sclk && !ee_di;
      got_busy_ready = req_ready;
      got_cyc = 0;
      while (1) begin
         @(posedge clk);
         #1;
         got_cyc++;
         if (got_cyc == ready_at) wr_do = 1'b1;
         if (rsp_done || got_cyc > 5000) break;
      end
      got_rdata = rsp_rdata;
      got_to = rsp_timeout;
      @(posedge clk);
      #1;
      got_done_after = rsp_done;
      wr_mode = 1'b0;
   endtask

   task automatic t_reset;
      check("R12", "cs", 32'(ee_cs), 0);
      check("R12", "sclk", 32'(ee_sclk), 0);
      check("R12", "di", 32'(ee_di), 0);
      check("R12", "ready", 32'(req_ready), 1);
      check("R12", "done", 32'(rsp_done), 0);
   endtask

   task automatic t_read_word(input logic [AW-1:0] a, input logic [15:0] w);
      int n = 1 + 3 + AW + 16 + 1;
      run_req(3'd0, {1'b0, a}, 16'h0, 3 + AW, 16, w, -1);
      check("R1", "entry state", 32'(got_acc_ok), 1);
      check("R1", "dummy pulse di", 32'(m_entry_bad), 0);
      check("R10", "ready while busy", 32'(got_busy_ready), 0);
      check("R2", "read frame", m_cap, 32'({3'b110, a}));
      check("R3", "rdata", 32'(got_rdata), 32'(w));
      check("R3", "quiet di", 32'(m_quiet_bad), 0);
      check("R9", "exit pulse", 32'(m_exit_seen), 1);
      check("R9", "pulse count", 32'(m_edges), 32'(n));
      check("R9", "done single", 32'(got_done_after), 0);
      check("R11", "read cycles", 32'(got_cyc), 32'(2 * BP * n));
      check("R8", "no timeout", 32'(got_to), 0);
   endtask

   task automatic t_read_byte(input logic [AW:0] a, input logic [7:0] b);
      int n = 1 + 4 + AW + 8 + 1;
      run_req(3'd1, a, 16'h0, 4 + AW, 8, {8'h00, b}, -1);
      check("R4", "byte frame", m_cap, 32'({3'b110, a}));
      check("R4", "byte rdata", 32'(got_rdata), 32'({8'h00, b}));
      check("R4", "byte pulses", 32'(m_edges), 32'(n));
      check("R11", "byte cycles", 32'(got_cyc), 32'(2 * BP * n));
   endtask

   task automatic t_ctrl(input logic en);
      int n = 1 + 3 + AW + 1;
      logic [31:0] exp = en ? 32'({5'b10011, {(AW-2){1'b0}}})
                            : 32'({5'b10000, {(AW-2){1'b0}}});
      run_req(en ? 3'd3 : 3'd4, '1, 16'hFFFF, 3 + AW, 0, 16'h0, -1);
      check("R5", "ctrl frame", m_cap, exp);
      check("R5", "ctrl pulses", 32'(m_edges), 32'(n));
      check("R11", "ctrl cycles", 32'(got_cyc), 32'(2 * BP * n));
      check("R4", "ctrl rdata zero", 32'(got_rdata), 0);
   endtask

   task automatic t_write(input logic [AW-1:0] a, input logic [15:0] d,
                          input int ready_at, input int exp_k, input logic exp_to);
      int base = 2 * BP * (1 + 3 + AW + 16);
      run_req(3'd2, {1'b0, a}, d, 3 + AW + 16, 0, 16'h0, ready_at);
      check("R6", "write frame", m_cap, 32'({3'b101, a, d}));
      check("R6", "write pulses", 32'(m_edges), 32'(1 + 3 + AW + 16 + 1));
      check("R7", "write cycles", 32'(got_cyc),
            32'(base + BS + (exp_k - 1) * BQ + 2 * BP));
      check("R8", "timeout flag", 32'(got_to), 32'(exp_to));
      check("R9", "write exit", 32'(m_exit_seen), 1);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      t_read_word(6'h2A, 16'hB3C5);
      t_read_word(6'h00, 16'h8001);
      t_read_byte(7'h55, 8'hA6);
      t_ctrl(1'b1);
      t_ctrl(1'b0);
      // Ready level raised after sample 2 (cycle 112), seen at sample 3.
      t_write(6'h13, 16'h5AC3, 115, 3, 1'b0);
      // Ready already high at the first sample.
      t_write(6'h3F, 16'h0001, 2, 1, 1'b0);
      // Never ready: POLL_MAX samples then timeout.
      t_write(6'h01, 16'hFFFF, -1, BM, 1'b1);
      t_read_word(6'h3F, 16'h7FFE);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule